// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of one-bit ownership tokens that two agents, called the left and right ports, use to agree on who may touch a shared resource. Each port has its own select, token index, write strobe, output enable and data bus. A port asks for a token by writing a value whose bit 0 is zero. It gives the token back by writing a value whose bit 0 is one. It learns whether it holds a token by reading it.

A request that hits a token held by the other side does not fail. It is kept as pending, and the token passes to the waiting port in the same clock edge at which the holder hands it back. Reads are local to each port: a port sees 0 only for tokens it holds itself.

The design is fully synchronous. Writes take effect at the rising clock edge. Read data is combinational from the registered token state.

Top module: `sem_bank`

## Requirements
- R1: After reset every token is free and nothing is pending, so a read of any index from either port returns all ones.
- R2: No token is ever held by both ports; two same-cycle reads of one index never both return 0.
- R3: A read (select 1, write 0, output enable 1) returns, on every data bit, 0 if the reading port holds the addressed token and 1 if the token is free or held by the other port.
- R4: A write (select 1, write 1) with data bit 0 equal to 0 to a free token makes the writing port its holder from the next cycle.
- R5: A holder writing data bit 0 equal to 1 frees the token from the next cycle when the other port has no pending request.
- R6: A write of 0 to a token held by the other port is stored as pending. When the holder writes 1, ownership passes to the waiting port at that same edge.
- R7: If both ports write 0 to the same free token in one cycle, the left port becomes holder and the right request becomes pending.
- R8: Only data bit 0 of a write is used; all other write data bits are ignored.
- R9: When a port is not reading, its read data is all ones.
- R10: A port that does not hold a token and writes 1 to it withdraws its own pending request and leaves the holder unchanged.
- R11: Write strobes with the select low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sel | input | 1 | Left port semaphore select |
| l_wr | input | 1 | Left port write (1) or read (0) |
| l_oe | input | 1 | Left port output enable for reads |
| l_idx | input | 3 | Left port token index |
| l_wdata | input | 16 | Left port write data (bit 0 used) |
| l_rdata | output | 16 | Left port read data |
| r_sel | input | 1 | Right port semaphore select |
| r_wr | input | 1 | Right port write (1) or read (0) |
| r_oe | input | 1 | Right port output enable for reads |
| r_idx | input | 3 | Right port token index |
| r_wdata | input | 16 | Right port write data (bit 0 used) |
| r_rdata | output | 16 | Right port read data |

## Verification
The assertions assume that every input is a clean, known value at each rising edge and that a port performs at most one operation per cycle, so a take and a give from the same port never meet. The bench drives all inputs on the falling edge from a single task, so each port presents exactly one read, write or idle per cycle. Its random phase confines indices to two tokens, so contention, pending requests, withdrawals and simultaneous takes occur often while the inputs stay within these assumptions.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'b00,
    OWN_LEFT  = 2'b01,
    OWN_RIGHT = 2'b10
  } sem_owner_t;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
  parameter int N_SEM = 8,
  parameter int IDX_W = $clog2(N_SEM)
) (
  input  logic             sel,
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  input  logic             wbit,
  output logic [N_SEM-1:0] take,
  output logic [N_SEM-1:0] give
);
  logic wr_act;
  assign wr_act = sel & wr;

  for (genvar i = 0; i < N_SEM; i++) begin : g_dec
    logic hit;
    assign hit     = wr_act & (idx == IDX_W'(i));
    assign take[i] = hit & ~wbit;
    assign give[i] = hit & wbit;
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take_l,
  input  logic give_l,
  input  logic take_r,
  input  logic give_r,
  output logic held_l,
  output logic held_r
);
  sem_owner_t own_q, own_d;
  logic pend_l_q, pend_l_d, pend_r_q, pend_r_d;
  logic want_l, want_r, keep_l, keep_r, upd_en;

  always_comb begin
    want_l = (pend_l_q | take_l) & ~give_l & (own_q != OWN_LEFT);
    want_r = (pend_r_q | take_r) & ~give_r & (own_q != OWN_RIGHT);
    keep_l = (own_q == OWN_LEFT) & ~give_l;
    keep_r = (own_q == OWN_RIGHT) & ~give_r;
    upd_en = take_l | give_l | take_r | give_r;
    own_d    = OWN_NONE;
    pend_l_d = 1'b0;
    pend_r_d = 1'b0;
    if (keep_l) begin
      own_d    = OWN_LEFT;
      pend_r_d = want_r;
    end else if (keep_r) begin
      own_d    = OWN_RIGHT;
      pend_l_d = want_l;
    end else if (want_l) begin
      own_d    = OWN_LEFT;
      pend_r_d = want_r;
    end else if (want_r) begin
      own_d    = OWN_RIGHT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q    <= OWN_NONE;
      pend_l_q <= 1'b0;
      pend_r_q <= 1'b0;
    end else if (upd_en) begin
      own_q    <= own_d;
      pend_l_q <= pend_l_d;
      pend_r_q <= pend_r_d;
    end
  end

  assign held_l = (own_q == OWN_LEFT);
  assign held_r = (own_q == OWN_RIGHT);

  // R6: a pending request only exists while the other port holds the token
  a_r6_pend_needs_holder: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_l_q |-> held_r) and (pend_r_q |-> held_l));
  // R6: release by the holder hands the token to the waiting port
  a_r6_handover: assert property (@(posedge clk) disable iff (!rst_n)
    (held_l && give_l && pend_r_q && !give_r) |=> held_r);
  // R7: simultaneous takes on a free token favour the left port
  a_r7_left_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!held_l && !held_r && take_l && take_r) |=> (held_l && pend_r_q));
  // R5: uncontested release frees the token
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (held_l && give_l && !pend_r_q && !take_r) |=> (!held_l && !held_r));
  // R11: no write strobe means no state change
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_l && !give_l && !take_r && !give_r) |=> ($stable(own_q) && $stable(pend_l_q)));
endmodule

// File: rtl/sem_read_mux.sv
module sem_read_mux #(
  parameter int N_SEM  = 8,
  parameter int IDX_W  = $clog2(N_SEM),
  parameter int DATA_W = 16
) (
  input  logic [N_SEM-1:0]  held,
  input  logic              sel,
  input  logic              wr,
  input  logic              oe,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] rdata
);
  logic rd_act;
  assign rd_act = sel & ~wr & oe;

  always_comb begin
    if (rd_act) rdata = {DATA_W{~held[idx]}};
    else        rdata = {DATA_W{1'b1}};
  end
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int N_SEM  = 8,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(N_SEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel,
  input  logic              l_wr,
  input  logic              l_oe,
  input  logic [IDX_W-1:0]  l_idx,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel,
  input  logic              r_wr,
  input  logic              r_oe,
  input  logic [IDX_W-1:0]  r_idx,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  logic [N_SEM-1:0] take_l, give_l, take_r, give_r, held_l, held_r;

  sem_port_decode #(.N_SEM(N_SEM), .IDX_W(IDX_W)) u_dec_l (
    .sel(l_sel), .wr(l_wr), .idx(l_idx), .wbit(l_wdata[0]),
    .take(take_l), .give(give_l));

  sem_port_decode #(.N_SEM(N_SEM), .IDX_W(IDX_W)) u_dec_r (
    .sel(r_sel), .wr(r_wr), .idx(r_idx), .wbit(r_wdata[0]),
    .take(take_r), .give(give_r));

  for (genvar i = 0; i < N_SEM; i++) begin : g_cell
    sem_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .take_l(take_l[i]), .give_l(give_l[i]),
      .take_r(take_r[i]), .give_r(give_r[i]),
      .held_l(held_l[i]), .held_r(held_r[i]));
  end

  sem_read_mux #(.N_SEM(N_SEM), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_rd_l (
    .held(held_l), .sel(l_sel), .wr(l_wr), .oe(l_oe), .idx(l_idx), .rdata(l_rdata));

  sem_read_mux #(.N_SEM(N_SEM), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_rd_r (
    .held(held_r), .sel(r_sel), .wr(r_wr), .oe(r_oe), .idx(r_idx), .rdata(r_rdata));

  // R2: both ports never see ownership of the same token at once
  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_sel && !l_wr && l_oe && r_sel && !r_wr && r_oe && (l_idx == r_idx)
      && !l_rdata[0] && !r_rdata[0]));
  // R9: idle ports present all ones
  a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((!(l_sel && !l_wr && l_oe)) |-> (&l_rdata)) and
    ((!(r_sel && !r_wr && r_oe)) |-> (&r_rdata)));
  // R3: a read drives the same value on every bit
  a_r3_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    ((&l_rdata) || (l_rdata == '0)) && ((&r_rdata) || (r_rdata == '0)));
endmodule

// File: tb/sim_sem_bank.sv
module sim_sem_bank;
  localparam int DW = 16;
  logic clk, rst_n;
  logic l_sel, l_wr, l_oe, r_sel, r_wr, r_oe;
  logic [2:0] l_idx, r_idx;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

  int n_run, n_fail, cyc;
  int own [8];   // 0 free, 1 left, 2 right
  bit pl [8];
  bit pr [8];

  sem_bank u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired: actual %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(string tag,
      bit ls, bit lw, bit lo, int li, logic [DW-1:0] ld,
      bit rs, bit rw, bit ro, int ri, logic [DW-1:0] rd);
    bit lrd, rrd, lt, lg, rt, rg;
    @(negedge clk);
    l_sel = ls; l_wr = lw; l_oe = lo; l_idx = 3'(li); l_wdata = ld;
    r_sel = rs; r_wr = rw; r_oe = ro; r_idx = 3'(ri); r_wdata = rd;
    #1;
    lrd = ls && !lw && lo;
    rrd = rs && !rw && ro;
    chk(lrd ? {tag, " R3 left"}  : {tag, " R9 left"},  l_rdata,
        (lrd && own[li] == 1) ? '0 : '1);
    chk(rrd ? {tag, " R3 right"} : {tag, " R9 right"}, r_rdata,
        (rrd && own[ri] == 2) ? '0 : '1);
    for (int i = 0; i < 8; i++) begin
      lt = ls && lw && li == i && !ld[0];
      lg = ls && lw && li == i && ld[0];
      rt = rs && rw && ri == i && !rd[0];
      rg = rs && rw && ri == i && rd[0];
      if (lg) begin if (own[i] == 1) own[i] = 0; pl[i] = 0; end
      if (rg) begin if (own[i] == 2) own[i] = 0; pr[i] = 0; end
      if (own[i] == 0) begin
        if (pl[i] || lt) begin
          own[i] = 1; pl[i] = 0;
          if (pr[i] || rt) pr[i] = 1;
        end else if (pr[i] || rt) begin
          own[i] = 2; pr[i] = 0;
        end
      end else if (own[i] == 1) begin
        if (rt) pr[i] = 1;
      end else begin
        if (lt) pl[i] = 1;
      end
    end
  endtask

  task automatic rd_both(string tag, int i);
    step(tag, 1, 0, 1, i, '0, 1, 0, 1, i, '0);
  endtask

  initial begin
    n_run = 0; n_fail = 0; cyc = 0;
    for (int i = 0; i < 8; i++) begin own[i] = 0; pl[i] = 0; pr[i] = 0; end
    l_sel = 0; l_wr = 0; l_oe = 0; l_idx = 0; l_wdata = 0;
    r_sel = 0; r_wr = 0; r_oe = 0; r_idx = 0; r_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < 8; i++) rd_both("R1 reset", i);
    // R4 and R8: take with upper bits set
    step("R4 take", 1, 1, 0, 3, 16'hFFFE, 0, 0, 0, 0, '0);
    rd_both("R4 held", 3);
    // R6: right request is queued
    step("R6 queue", 0, 0, 0, 0, '0, 1, 1, 0, 3, 16'h0000);
    rd_both("R6 pend", 3);
    // R8: release with upper bits clear
    step("R8 give", 1, 1, 0, 3, 16'h0001, 0, 0, 0, 0, '0);
    rd_both("R6 handed", 3);
    // R5: right releases
    step("R5 give", 0, 0, 0, 0, '0, 1, 1, 0, 3, 16'hFFFF);
    rd_both("R5 free", 3);
    // R7: tie
    step("R7 tie", 1, 1, 0, 5, '0, 1, 1, 0, 5, '0);
    rd_both("R7 left", 5);
    step("R7 give", 1, 1, 0, 5, 16'h0001, 0, 0, 0, 0, '0);
    rd_both("R7 right", 5);
    // R10: non-holder give leaves holder; withdrawal
    step("R10 lgive", 1, 1, 0, 5, 16'h0001, 0, 0, 0, 0, '0);
    rd_both("R10 kept", 5);
    step("R10 lreq", 1, 1, 0, 5, '0, 0, 0, 0, 0, '0);
    step("R10 wdraw", 1, 1, 0, 5, 16'h0001, 0, 0, 0, 0, '0);
    step("R10 rgive", 0, 0, 0, 0, '0, 1, 1, 0, 5, 16'h0001);
    rd_both("R10 free", 5);
    // R11: select low
    step("R11 nosel", 0, 1, 0, 0, '0, 0, 1, 0, 0, '0);
    rd_both("R11 still", 0);
    // R9: oe low read
    step("R9 oe", 1, 0, 0, 0, '0, 1, 0, 0, 0, '0);

    for (int k = 0; k < 4000; k++) begin
      step("R2 rnd",
        1'($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom_range(0, 3) != 0),
        $urandom_range(0, 1), DW'($urandom),
        1'($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom_range(0, 3) != 0),
        $urandom_range(0, 1), DW'($urandom));
    end
    for (int i = 0; i < 8; i++) rd_both("R2 final", i);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule